// File: doc/BRIEF.md
# Interrupt Request Latch with Acknowledge

This block is the request side of an eight-line programmable interrupt controller. Each request line passes through a synchroniser and is recorded in a request register. A per-line trigger select puts the line in edge mode or level mode. A mask register hides lines from the processor. An in-service register records which interrupts are being handled. A fixed-priority resolver picks the winning line, with line 0 the most urgent. The result raises `irq_out` whenever an unmasked request outranks everything currently in service.

The processor answers with two acknowledge strobes, and the vector is taken on the second one. If the winning request is still present at that point, its request bit is cleared and its in-service bit is set. The block then returns the base vector plus the line number. If the request has disappeared by then, the block returns the spurious vector (base plus 7) and no in-service bit changes. A non-specific end-of-interrupt strobe retires the most urgent in-service bit.

In both trigger modes a falling request line cancels its pending request. The only difference between the modes is that edge mode needs a fresh rising edge to record a request. The vector output is a one-cycle `vec_valid` pulse with no ready input: the acknowledge itself is the request for data, so no back-pressure exists. The consumer must capture `vec_out` in the cycle that `vec_valid` is high.

Top module: `irqf_top`

## Requirements
- R1: After reset the mask register is all ones, the request and in-service registers are clear, every input counts as previously low, and `irq_out` and `vec_valid` are low.
- R2: In edge mode (`trig_level` bit = 0) a request is recorded only on a low-to-high change of the synchronised line. A line held high does not request again after being serviced.
- R3: In level mode (`trig_level` bit = 1) a high synchronised line sets its request bit without needing an edge. The line therefore requests again once its service ends.
- R4: In either mode a high-to-low change of a line clears its pending request. `irq_out` falls when no presentable request remains.
- R5: A masked line (`mask` bit = 1) never drives `irq_out`, but its request is still recorded. Clearing the mask bit presents a request that is still pending.
- R6: Priority is fixed, with line 0 highest. The vector is `vec_base` plus the line number, computed modulo 256.
- R7: The first `ack_strobe` arms the handshake. On the second, the winning request bit is cleared and its in-service bit is set. One clock later `vec_valid` is high for exactly one cycle, with the vector on `vec_out`.
- R8: If no request is presentable at the second acknowledge, `vec_out` is `vec_base` + 7 and the in-service register is left unchanged.
- R9: A request is presented only if its line number is lower than every line whose in-service bit is set.
- R10: `eoi_strobe` clears the lowest-numbered set in-service bit.
- R11: Inputs pass through two synchroniser stages and the request register, so a change on `req_in` reaches `irq_out` three clocks later. No pulse filtering is applied: a single-cycle pulse in edge mode is recorded, and it is then cancelled when the line falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Asynchronous request lines, line 0 most urgent |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | New mask value, 1 = line hidden |
| trig_level | input | 8 | Per-line trigger select, 1 = level, 0 = edge |
| vec_base | input | 8 | Base vector added to the line number |
| ack_strobe | input | 1 | Acknowledge strobe, two per handshake |
| eoi_strobe | input | 1 | Non-specific end-of-interrupt strobe |
| irq_out | output | 1 | Interrupt line to the processor |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | One-cycle qualifier for `vec_out` |

## Verification
Every line is swept in both trigger modes and with two base values, one of which makes the vector addition wrap. For each line the sweep checks the vector, then the behaviour after service. A line held high stays silent in edge mode but requests again in level mode, and that difference alone separates the two trigger rules. Overlapping requests on several lines separate fixed priority from in-service blocking and from the end-of-interrupt order. A request withdrawn between the two acknowledges distinguishes the spurious path from a genuine line-7 vector, because a later lower-priority line is still presented only if no in-service bit was set. A single-cycle pulse and a masked-then-unmasked line show that nothing filters short requests and that the mask gates presentation rather than recording.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_ARMED = 1'b1
  } ack_phase_e;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int NUM_LINES   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] async_i,
  output logic [NUM_LINES-1:0] sync_o
);
  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/irqf_req_reg.sv
module irqf_req_reg #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] irr_o
);
  logic [NUM_LINES-1:0] prev_q, irr_q, rise, fall, irr_nxt;

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb begin
      if (level_i[i]) irr_nxt[i] = sync_i[i] & ~clr_i[i];
      else            irr_nxt[i] = (irr_q[i] | rise[i]) & sync_i[i] & ~clr_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= sync_i;
      irr_q  <= irr_nxt;
    end
  end

  assign irr_o = irr_q;

  AST_EDGE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & ~$past(irr_q) & ~$past(level_i) & ~$past(rise)) == '0)); // R2
  AST_FALL_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    ((irr_q & $past(fall)) == '0)); // R4
endmodule

// File: rtl/irqf_resolver.sv
module irqf_resolver #(
  parameter int NUM_LINES = 8,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] isr_i,
  output logic [NUM_LINES-1:0] win_oh_o,
  output logic [IDX_W-1:0]     win_idx_o,
  output logic                 win_any_o
);
  logic [NUM_LINES-1:0] allowed, cand;

  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      seen       = seen | isr_i[i];
      allowed[i] = ~seen;
    end
  end

  assign cand = irr_i & ~mask_i & allowed;

  always_comb begin
    logic found;
    found     = 1'b0;
    win_oh_o  = '0;
    win_idx_o = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!found && cand[i]) begin
        found       = 1'b1;
        win_oh_o[i] = 1'b1;
        win_idx_o   = IDX_W'(i);
      end
    end
    win_any_o = found;
  end

  always_comb begin
    AST_WIN_ONEHOT: assert ($onehot0(win_oh_o)); // R6
  end
endmodule

// File: rtl/irqf_top.sv
module irqf_top #(
  parameter int NUM_LINES   = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] req_in,
  input  logic                 mask_we,
  input  logic [NUM_LINES-1:0] mask_wdata,
  input  logic [NUM_LINES-1:0] trig_level,
  input  logic [VEC_W-1:0]     vec_base,
  input  logic                 ack_strobe,
  input  logic                 eoi_strobe,
  output logic                 irq_out,
  output logic [VEC_W-1:0]     vec_out,
  output logic                 vec_valid
);
  import irqf_pkg::*;

  logic [NUM_LINES-1:0] sync_req, irr, mask_q, isr_q, win_oh, ack_clr, eoi_oh;
  logic [IDX_W-1:0]     win_idx;
  logic                 win_any, ack_second;
  ack_phase_e           phase_q;

  irqf_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_i(req_in), .sync_o(sync_req));

  irqf_req_reg #(.NUM_LINES(NUM_LINES)) req_i (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_req), .level_i(trig_level),
    .clr_i(ack_clr), .irr_o(irr));

  irqf_resolver #(.NUM_LINES(NUM_LINES)) res_i (
    .irr_i(irr), .mask_i(mask_q), .isr_i(isr_q),
    .win_oh_o(win_oh), .win_idx_o(win_idx), .win_any_o(win_any));

  assign irq_out    = win_any;
  assign ack_second = ack_strobe && (phase_q == ACK_ARMED);
  assign ack_clr    = ack_second ? win_oh : '0;

  always_comb begin
    logic found;
    found  = 1'b0;
    eoi_oh = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (!found && isr_q[i]) begin
        found     = 1'b1;
        eoi_oh[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '1;
      isr_q     <= '0;
      phase_q   <= ACK_IDLE;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      isr_q     <= (isr_q & ~(eoi_strobe ? eoi_oh : '0)) | ack_clr;
      vec_valid <= ack_second;
      if (ack_strobe)
        phase_q <= (phase_q == ACK_IDLE) ? ACK_ARMED : ACK_IDLE;
      if (ack_second)
        vec_out <= win_any ? vec_base + VEC_W'(win_idx)
                           : vec_base + VEC_W'(NUM_LINES - 1);
    end
  end

  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> ((irr & ~mask_q) != '0)); // R5
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_second && win_any) |=> ((isr_q & $past(win_oh)) == $past(win_oh))); // R7
  AST_ACK_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_second && win_any) |=> ((irr & $past(win_oh)) == '0)); // R7
  AST_VEC_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid); // R7
  AST_SPURIOUS_NO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_second && !win_any && !eoi_strobe) |=> $stable(isr_q)); // R8
  AST_EOI_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_strobe && !ack_second && (isr_q != '0)) |=> ((isr_q & $past(eoi_oh)) == '0)); // R10
endmodule

// File: tb/irqf_top_tb_top.sv
module irqf_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req_in = '0, mask_wdata = '0, trig_level = '0;
  logic         mask_we = 1'b0, ack_strobe = 1'b0, eoi_strobe = 1'b0;
  logic [7:0]   vec_base = '0;
  logic         irq_out, vec_valid;
  logic [7:0]   vec_out;
  int           n_cmp = 0, n_bad = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqf_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .trig_level(trig_level), .vec_base(vec_base),
    .ack_strobe(ack_strobe), .eoi_strobe(eoi_strobe), .irq_out(irq_out),
    .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic set_mask(input logic [N-1:0] v);
    mask_we = 1'b1; mask_wdata = v; step(1); mask_we = 1'b0;
  endtask

  task automatic pulse_eoi();
    eoi_strobe = 1'b1; step(1); eoi_strobe = 1'b0;
  endtask

  task automatic ack_pair(input string tag, input logic [7:0] exp_vec);
    ack_strobe = 1'b1; step(1); ack_strobe = 1'b0; step(1);
    ack_strobe = 1'b1; step(1); ack_strobe = 1'b0;
    chk({tag, " R7 valid"}, vec_valid, 1);
    chk({tag, " R6 vector"}, vec_out, exp_vec);
    step(1);
    chk({tag, " R7 single pulse"}, vec_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] bases [2];
    bases[0] = 8'h20; bases[1] = 8'hFC;
    step(3); rst_n = 1'b1;
    // R1 reset state, mask all ones
    chk("R1 irq after reset", irq_out, 0);
    chk("R1 valid after reset", vec_valid, 0);
    trig_level = '1; req_in = 8'h01; step(3);
    chk("R1 mask resets to ones", irq_out, 0);
    set_mask('0);
    chk("R5 unmask presents level request", irq_out, 1);
    req_in = '0; step(3);
    chk("R4 level line falls", irq_out, 0);

    // sweep: base x mode x line
    for (int b = 0; b < 2; b++) begin
      for (int m = 0; m < 2; m++) begin
        for (int i = 0; i < N; i++) begin
          vec_base = bases[b];
          trig_level = (m == 1) ? '1 : '0;
          req_in = 8'(1 << i);
          step(2);
          chk("R11 not before three clocks", irq_out, 0);
          step(1);
          chk(m ? "R3 level request" : "R2 edge request", irq_out, 1);
          ack_pair("sweep", 8'(bases[b] + 8'(i)));
          step(1);
          chk("R9 own in-service blocks", irq_out, 0);
          pulse_eoi(); step(1);
          chk(m ? "R3 level re-request" : "R2 held high no re-request", irq_out, 32'(m));
          req_in = '0; step(3);
          chk("R4 line low gives no irq", irq_out, 0);
        end
      end
    end

    // priority, nesting and end-of-interrupt order
    vec_base = 8'h40; trig_level = '0;
    req_in = 8'h28; step(3);
    ack_pair("prio line3", 8'h43);
    chk("R9 line5 blocked by line3", irq_out, 0);
    req_in = 8'h2A; step(3);
    chk("R9 line1 nests above line3", irq_out, 1);
    ack_pair("prio line1", 8'h41);
    pulse_eoi(); step(1);
    chk("R10 first eoi retires line1 only", irq_out, 0);
    pulse_eoi(); step(1);
    chk("R10 second eoi retires line3", irq_out, 1);
    ack_pair("prio line5", 8'h45);
    pulse_eoi(); req_in = '0; step(3);

    // spurious acknowledge
    req_in = 8'h10; step(3);
    chk("R2 line4 request", irq_out, 1);
    ack_strobe = 1'b1; step(1); ack_strobe = 1'b0;
    req_in = '0; step(3);
    chk("R4 drop after first ack", irq_out, 0);
    ack_strobe = 1'b1; step(1); ack_strobe = 1'b0;
    chk("R8 spurious valid", vec_valid, 1);
    chk("R8 spurious vector", vec_out, 8'h47);
    req_in = 8'h40; step(3);
    chk("R8 no in-service set", irq_out, 1);
    ack_pair("after spurious", 8'h46);
    pulse_eoi(); req_in = '0; step(3);

    // cancel and mask in edge mode
    req_in = 8'h04; step(3);
    chk("R2 line2 request", irq_out, 1);
    req_in = '0; step(3);
    chk("R4 edge request cancelled", irq_out, 0);
    set_mask(8'h04);
    req_in = 8'h04; step(3);
    chk("R5 masked line silent", irq_out, 0);
    set_mask('0);
    chk("R5 recorded while masked", irq_out, 1);
    ack_pair("unmasked line2", 8'h42);
    pulse_eoi(); req_in = '0; step(3);

    // single-cycle pulse, no filtering
    req_in = 8'h01; step(1); req_in = '0; step(2);
    chk("R11 short pulse recorded", irq_out, 1);
    step(1);
    chk("R11 short pulse cancelled on fall", irq_out, 0);

    finish_run();
  end
endmodule